// File: doc/BRIEF.md
# NAND Erase Command and Status Interpreter

This block sits on the device side of a NAND flash pin interface. It models the command register and the status register as the bus sees them. Bytes are taken on the rising edge of write-enable while chip-enable is low. The command-latch and address-latch pins mark each byte as a command, an address or data. A block erase is started only by a complete sequence: the setup command, a fixed number of address bytes, then the confirm command. After that the part reports busy for a parameterized number of clocks. The address is kept with its page-offset bits cleared, so only the block number survives.

A status command switches the read path to the status byte. The switch stays in force for any number of read cycles, until some other command is accepted. While the status path is selected and both chip-enable and read-enable are low, the block drives the status byte onto the bus. Bit 0 is the error flag, bit 6 is ready and bit 7 is not-write-protected. All other bits read as zero.

Top module: `nand_cmd_status`

## Requirements
- R1: A byte is accepted only on the clock where a rising edge of `we_n` is seen while `ce_n` is low. With `cle` high and `ale` low it is a command. With `ale` high and `cle` low it is an address byte. With both low it is data. A byte written while `ce_n` is high has no effect.
- R2: The sequence command 8'h60, two address bytes, command 8'hD0 with `wp_n` high drives `rb_n` low. `rb_n` falls on the clock after the confirm byte is accepted and stays low for exactly BUSY_CYCLES clocks.
- R3: When an erase starts, `erase_addr` takes the value {second address byte, first address byte} with bits [DROP_BITS-1:0] forced to zero. With the defaults, 8'hB6 then 8'h5A gives 16'h5AA0. The value stays unchanged while busy.
- R4: During setup or while waiting for the confirm, the erase is cancelled and `rb_n` stays high when any of these arrives: a data byte, an address byte beyond the expected count, or a command other than 8'hD0 or 8'h60. A further 8'h60 restarts the setup with a fresh address count.
- R5: A confirm accepted while `wp_n` is low leaves `rb_n` high and `erase_addr` unchanged, and sets status bit 0 to 1.
- R6: A confirm accepted while `wp_n` is high clears status bit 0 to 0.
- R7: Command 8'h70 selects the status path. While it is selected, `io_oe` is 1 exactly when `ce_n` and `re_n` are both low. Repeated read cycles keep returning the live status without another command.
- R8: The status byte holds the error flag in bit 0, zero in bits 1 to 5, `rb_n` in bit 6 and `wp_n` in bit 7. Bits above 7 of `io_out` are zero.
- R9: The status path is deselected by any accepted command other than 8'h70 while not busy, including 8'h00 and 8'h50. With the status path deselected, `io_oe` and `io_out` are zero.
- R10: While busy, every command except 8'h70 is ignored. It neither leaves the status path nor starts a new erase. Command 8'h70 still selects the status path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks the byte as a command |
| ale | input | 1 | Marks the byte as an address |
| we_n | input | 1 | Write enable, byte taken on its rising edge |
| re_n | input | 1 | Read enable, active low |
| wp_n | input | 1 | Write protect, active low |
| cmd_in | input | 8 | Command, address or data byte |
| io_out | output | IO_W | Read data (status byte, zero extended) |
| io_oe | output | 1 | Read data drive enable |
| rb_n | output | 1 | Ready (1) / busy (0) |
| erase_addr | output | ADDR_CYCLES*8 | Block-aligned address of the last started erase |

## Verification
The erase sequence is driven whole, then broken at each position. The breaks are a non-confirm command after the address bytes, a surplus address byte, a data byte during addressing, and a repeated setup with new addresses. This separates a correct cancel from a restart and from a wrongly started erase. Confirms with write protect active and inactive tell the error-setting path apart from the error-clearing path. Status reads are made before, during and after busy, and after read and ignored commands. These show that the mode is sticky, that bit 6 follows busy, and that commands are blocked while busy. Writes with chip enable high must leave every output as it was.

// File: rtl/nand_if_pkg.sv
package nand_if_pkg;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;

  typedef enum logic [1:0] {
    ER_IDLE,
    ER_ADDR,
    ER_CONF,
    ER_BUSY
  } er_state_e;
endpackage

// File: rtl/nand_latch_decode.sv
module nand_latch_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic cle,
  input  logic ale,
  output logic cmd_stb,
  output logic adr_stb,
  output logic dat_stb
);
  logic we_q;
  logic take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  // rising edge of the write strobe seen with the chip selected
  assign take    = !ce_n && we_n && !we_q;
  assign cmd_stb = take && cle && !ale;
  assign adr_stb = take && ale && !cle;
  assign dat_stb = take && !cle && !ale;
endmodule

// File: rtl/nand_erase_fsm.sv
module nand_erase_fsm
  import nand_if_pkg::*;
#(
  parameter int BUSY_CYCLES = 40,
  parameter int ADDR_CYCLES = 2,
  parameter int DROP_BITS   = 5,
  localparam int AW = ADDR_CYCLES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic          adr_stb,
  input  logic          dat_stb,
  input  logic [7:0]    byte_in,
  input  logic          wp_n,
  output logic          busy,
  output logic          err,
  output logic [AW-1:0] erase_addr
);
  localparam int CW  = $clog2(BUSY_CYCLES + 1);
  localparam int ACW = $clog2(ADDR_CYCLES + 1);
  localparam logic [AW-1:0] KEEP_MASK = {AW{1'b1}} << DROP_BITS;

  er_state_e      state, nxt_state;
  logic [ACW-1:0] acnt, nxt_acnt;
  logic [CW-1:0]  bcnt, nxt_bcnt;
  logic           nxt_err;
  logic [AW-1:0]  addr_word, shifted;
  logic           start_erase;

  // byte order: first address byte ends in the lowest byte lane
  generate
    if (ADDR_CYCLES > 1) begin : g_multi
      assign shifted = {byte_in, addr_word[AW-1:8]};
    end else begin : g_single
      assign shifted = byte_in;
    end
  endgenerate

  always_comb begin
    nxt_state   = state;
    nxt_acnt    = acnt;
    nxt_bcnt    = bcnt;
    nxt_err     = err;
    start_erase = 1'b0;
    case (state)
      ER_IDLE: begin
        if (cmd_stb && byte_in == OP_ERASE_SETUP) begin
          nxt_state = ER_ADDR;
          nxt_acnt  = '0;
        end
      end
      ER_ADDR: begin
        if (adr_stb) begin
          if (acnt == ACW'(ADDR_CYCLES - 1)) nxt_state = ER_CONF;
          else                               nxt_acnt  = acnt + 1'b1;
        end else if (cmd_stb) begin
          nxt_acnt  = '0;
          nxt_state = (byte_in == OP_ERASE_SETUP) ? ER_ADDR : ER_IDLE;
        end else if (dat_stb) begin
          nxt_state = ER_IDLE;
        end
      end
      ER_CONF: begin
        if (cmd_stb && byte_in == OP_ERASE_GO) begin
          if (wp_n) begin
            nxt_state   = ER_BUSY;
            nxt_bcnt    = CW'(BUSY_CYCLES - 1);
            nxt_err     = 1'b0;
            start_erase = 1'b1;
          end else begin
            nxt_state = ER_IDLE;
            nxt_err   = 1'b1;
          end
        end else if (cmd_stb && byte_in == OP_ERASE_SETUP) begin
          nxt_state = ER_ADDR;
          nxt_acnt  = '0;
        end else if (cmd_stb || adr_stb || dat_stb) begin
          nxt_state = ER_IDLE;
        end
      end
      default: begin
        if (bcnt == '0) nxt_state = ER_IDLE;
        else            nxt_bcnt  = bcnt - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ER_IDLE;
      acnt       <= '0;
      bcnt       <= '0;
      err        <= 1'b0;
      addr_word  <= '0;
      erase_addr <= '0;
    end else begin
      state <= nxt_state;
      acnt  <= nxt_acnt;
      bcnt  <= nxt_bcnt;
      err   <= nxt_err;
      if (adr_stb && state == ER_ADDR) addr_word  <= shifted;
      if (start_erase)                 erase_addr <= addr_word & KEEP_MASK;
    end
  end

  assign busy = (state == ER_BUSY);
endmodule

// File: rtl/nand_status_path.sv
module nand_status_path
  import nand_if_pkg::*;
#(
  parameter int IO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_stb,
  input  logic [7:0]      byte_in,
  input  logic            busy,
  input  logic            err,
  input  logic            wp_n,
  input  logic            ce_n,
  input  logic            re_n,
  output logic [IO_W-1:0] io_out,
  output logic            io_oe
);
  logic       smode, nxt_smode;
  logic [7:0] sbyte;

  always_comb begin
    nxt_smode = smode;
    if (cmd_stb) begin
      if (byte_in == OP_STATUS) nxt_smode = 1'b1;
      else if (!busy)           nxt_smode = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smode <= 1'b0;
    else        smode <= nxt_smode;
  end

  assign sbyte = {wp_n, !busy, 5'b00000, err};
  assign io_oe = smode && !ce_n && !re_n;

  always_comb begin
    io_out = '0;
    if (io_oe) io_out[7:0] = sbyte;
  end
endmodule

// File: rtl/nand_cmd_status.sv
module nand_cmd_status #(
  parameter int IO_W        = 16,
  parameter int BUSY_CYCLES = 40,
  parameter int ADDR_CYCLES = 2,
  parameter int DROP_BITS   = 5,
  localparam int AW = ADDR_CYCLES * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            cle,
  input  logic            ale,
  input  logic            we_n,
  input  logic            re_n,
  input  logic            wp_n,
  input  logic [7:0]      cmd_in,
  output logic [IO_W-1:0] io_out,
  output logic            io_oe,
  output logic            rb_n,
  output logic [AW-1:0]   erase_addr
);
  logic cmd_stb, adr_stb, dat_stb;
  logic busy, err;

  nand_latch_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .cle     (cle),
    .ale     (ale),
    .cmd_stb (cmd_stb),
    .adr_stb (adr_stb),
    .dat_stb (dat_stb)
  );

  nand_erase_fsm #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .ADDR_CYCLES (ADDR_CYCLES),
    .DROP_BITS   (DROP_BITS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb    (cmd_stb),
    .adr_stb    (adr_stb),
    .dat_stb    (dat_stb),
    .byte_in    (cmd_in),
    .wp_n       (wp_n),
    .busy       (busy),
    .err        (err),
    .erase_addr (erase_addr)
  );

  nand_status_path #(.IO_W(IO_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_stb (cmd_stb),
    .byte_in (cmd_in),
    .busy    (busy),
    .err     (err),
    .wp_n    (wp_n),
    .ce_n    (ce_n),
    .re_n    (re_n),
    .io_out  (io_out),
    .io_oe   (io_oe)
  );

  assign rb_n = !busy;
endmodule

// File: rtl/nand_cmd_status_chk.sv
module nand_cmd_status_chk #(
  parameter int IO_W        = 16,
  parameter int BUSY_CYCLES = 40,
  parameter int AW          = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            re_n,
  input logic            wp_n,
  input logic [IO_W-1:0] io_out,
  input logic            io_oe,
  input logic            rb_n,
  input logic [AW-1:0]   erase_addr
);
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= 0;
    else if (!rb_n) low_cnt <= low_cnt + 1;
    else            low_cnt <= 0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_n) |-> low_cnt == BUSY_CYCLES); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_n && $past(!rb_n)) |-> $stable(erase_addr)); // R3
  AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> $past(wp_n)); // R5
  AST_OE_NEEDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (!ce_n && !re_n)); // R7
  AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (io_out[5:1] == 5'b0 && (io_out >> 8) == '0)); // R8
  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (io_out[6] == rb_n && io_out[7] == wp_n)); // R8
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !io_oe |-> io_out == '0); // R9
endmodule

bind nand_cmd_status nand_cmd_status_chk #(
  .IO_W        (IO_W),
  .BUSY_CYCLES (BUSY_CYCLES),
  .AW          (AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .re_n       (re_n),
  .wp_n       (wp_n),
  .io_out     (io_out),
  .io_oe      (io_oe),
  .rb_n       (rb_n),
  .erase_addr (erase_addr)
);

// File: tb/nand_cmd_status_tb.sv
`timescale 1ns/1ps
module nand_cmd_status_tb_top;
  localparam int IO_W = 16;
  localparam int BUSY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] cmd_in = 8'h00;
  logic [IO_W-1:0] io_out;
  logic io_oe, rb_n;
  logic [15:0] erase_addr;

  int vecs = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  nand_cmd_status #(.IO_W(IO_W), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .cmd_in(cmd_in), .io_out(io_out), .io_oe(io_oe),
    .rb_n(rb_n), .erase_addr(erase_addr)
  );

  // behavioural reference model
  int   m_busy;
  int   m_phase;   // 0 none, 1 addressing, 2 awaiting confirm
  int   m_na;
  bit   m_weq, m_smode, m_err;
  logic [7:0]  m_ab [2];
  logic [15:0] m_eaddr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_phase = 0; m_na = 0; m_weq = 1; m_smode = 0; m_err = 0;
      m_eaddr = 16'h0; m_ab[0] = 8'h0; m_ab[1] = 8'h0;
    end else begin
      bit was_busy, take;
      was_busy = (m_busy > 0);
      take = !ce_n && we_n && !m_weq;
      m_weq = we_n;
      if (m_busy > 0) m_busy--;
      if (take && cle && !ale) begin
        if (cmd_in == 8'h70) m_smode = 1;
        else if (!was_busy) m_smode = 0;
        if (!was_busy) begin
          if (cmd_in == 8'h60) begin
            m_phase = 1; m_na = 0;
          end else if (m_phase == 2 && cmd_in == 8'hD0) begin
            if (wp_n) begin
              m_busy = BUSY; m_err = 0;
              m_eaddr = {m_ab[1], m_ab[0]} & 16'hFFE0;
            end else m_err = 1;
            m_phase = 0;
          end else m_phase = 0;
        end
      end else if (take && ale && !cle) begin
        if (!was_busy) begin
          if (m_phase == 1) begin
            m_ab[m_na] = cmd_in; m_na++;
            if (m_na == 2) m_phase = 2;
          end else if (m_phase == 2) m_phase = 0;
        end
      end else if (take && !cle && !ale) begin
        if (!was_busy) m_phase = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edges
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic m_oe;
      logic [IO_W-1:0] m_out;
      m_oe  = m_smode && !ce_n && !re_n;
      m_out = '0;
      if (m_oe) m_out[7:0] = {wp_n, (m_busy == 0), 5'b0, m_err};
      chk("R2 rb_n vs model", rb_n, (m_busy == 0));
      chk("R3 erase_addr vs model", erase_addr, m_eaddr);
      chk("R7 io_oe vs model", io_oe, m_oe);
      chk("R8 io_out vs model", io_out, m_out);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic wr(input logic c, input logic a, input logic [7:0] b, input logic ce = 1'b0);
    @(negedge clk); ce_n = ce; cle = c; ale = a; cmd_in = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); wr(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b); wr(1'b0, 1'b1, b); endtask

  task automatic rd(output logic [IO_W-1:0] v, output logic oe);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); #2; v = io_out; oe = io_oe; re_n = 1'b1;
  endtask

  task automatic wait_ready();
    while (!rb_n) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [IO_W-1:0] v;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R2 ready after reset", rb_n, 1);
    chk("R9 bus quiet after reset", io_oe, 0);

    cmd(8'h70);
    rd(v, oe); chk("R7 status selected", oe, 1); chk("R8 idle status", v, 16'h00C0);
    rd(v, oe); chk("R7 status persists", v, 16'h00C0);

    cmd(8'h60); adr(8'hB6); adr(8'h5A); cmd(8'hD0);
    chk("R2 busy after confirm", rb_n, 0);
    cmd(8'h70);
    rd(v, oe); chk("R10 status while busy", v, 16'h0080);
    cmd(8'h00);
    rd(v, oe); chk("R10 read cmd ignored while busy", oe, 1);
    wait_ready();
    chk("R3 block address kept", erase_addr, 16'h5AA0);
    rd(v, oe); chk("R6 status after erase", v, 16'h00C0);

    cmd(8'h60); adr(8'h11); adr(8'h22); cmd(8'h00);
    @(negedge clk); chk("R4 other cmd cancels", rb_n, 1);
    cmd(8'h60); adr(8'h11); adr(8'h22); adr(8'h33); cmd(8'hD0);
    @(negedge clk); chk("R4 extra address cancels", rb_n, 1);
    cmd(8'h60); adr(8'h11); wr(1'b0, 1'b0, 8'h44); adr(8'h22); cmd(8'hD0);
    @(negedge clk); chk("R4 data byte cancels", rb_n, 1);
    chk("R4 address untouched", erase_addr, 16'h5AA0);
    cmd(8'h60); adr(8'h11); adr(8'h22); cmd(8'h60); adr(8'h1F); adr(8'h80); cmd(8'hD0);
    chk("R4 setup restart runs", rb_n, 0);
    wait_ready();
    chk("R3 offset bits dropped", erase_addr, 16'h8000);

    wp_n = 1'b0;
    cmd(8'h60); adr(8'h00); adr(8'h0F); cmd(8'hD0);
    @(negedge clk); chk("R5 protected no busy", rb_n, 1);
    chk("R5 address unchanged", erase_addr, 16'h8000);
    cmd(8'h70);
    rd(v, oe); chk("R5 error flag set", v, 16'h0041);

    wp_n = 1'b1;
    cmd(8'h60); adr(8'h00); adr(8'hFF); cmd(8'hD0);
    wait_ready();
    cmd(8'h70);
    rd(v, oe); chk("R6 error cleared", v, 16'h00C0);
    chk("R3 second address", erase_addr, 16'hFF00);

    wr(1'b1, 1'b0, 8'h60, 1'b1); wr(1'b0, 1'b1, 8'h01, 1'b1);
    wr(1'b0, 1'b1, 8'h02, 1'b1); wr(1'b1, 1'b0, 8'hD0, 1'b1);
    @(negedge clk); chk("R1 deselected writes ignored", rb_n, 1);
    rd(v, oe); chk("R1 status mode kept", oe, 1);

    cmd(8'h50);
    rd(v, oe); chk("R9 read cmd leaves status", oe, 0); chk("R9 bus zero", v, 16'h0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule